// File: doc/BRIEF.md
# Microwire Serial Memory Command Front End

This block is the slave side of a three-wire serial memory port for a 4096-bit store. It samples chip select, serial clock and serial data with the system clock, finds the framing start bit, and decodes a two-bit operation code followed by an address field. The address field is nine bits when the store is organised as bytes and eight bits when it is organised as 16-bit words. The organisation is chosen at elaboration time through `WORD_W`. Reads are answered directly from a register array inside the block: a single zero comes first, then the data, most significant bit first. The read keeps streaming through successive addresses for as long as select stays high.

Write-type commands are not carried out here. Write data is collected into a page buffer, and the command is handed to a separate self-timed programming sequencer when select is deasserted. That sequencer reads the buffer through a side port and updates the array through a write port. While the sequencer is working, it reports busy. When the host selects the port again, the block shows that busy or ready state on the data output.

Top module: `mw_cmd_if`

## Requirements
- R1: While waiting for a command, zeros sampled on `di` at `sk` rising edges are ignored. A one starts a command. The next 2 bits are the operation code, followed by `AW` address bits, MSB first. `AW` is 9 for 8-bit words and 8 for 16-bit words.
- R2: Operation code 2'b10 reads. On the `sk` rise that samples the last address bit, `do_o` is driven to 0 as a dummy bit. Each later rise presents the next data bit, MSB first.
- R3: If select stays high after a word's last bit, the next rise presents the MSB of the word at the next address. The address after the highest one is 0.
- R4: `do_oe` is 0 while select is low, while a header is being received, and while idle with no hand-off status pending.
- R5: Deasserting select abandons any partial command. A read after that needs a complete new start bit, operation code and address.
- R6: Writes are disabled after reset. Operation code 2'b00 with top address bits 2'b11 enables them, and with top address bits 2'b00 disables them. While disabled, WRITE, ERASE, erase-all and write-all produce no hand-off. Reads behave the same in both states.
- R7: Operation code 2'b01 writes. Each complete data word after the header goes into page slot (start address low `PAW` bits + n) mod `PAGE_WORDS`. When select falls, the hand-off carries kind 0, the start address, and the number of complete words capped at `PAGE_WORDS`. A trailing partial word is dropped, and with no complete word there is no hand-off.
- R8: Operation code 2'b11 hands off kind 1 with the address. Operation code 2'b00 with top address bits 2'b10 hands off kind 2 with address 0 and word count 0.
- R9: Operation code 2'b00 with top address bits 2'b01 takes one data word into slot 0 and hands off kind 3 with word count 1.
- R10: After a hand-off, while select is high and no command is in progress, `do_oe` is 1 and `do_o` is the inverse of `seq_busy`. A start bit clears this status.
- R11: `cmd_valid` is a single-cycle pulse in the cycle after the synchronised select falls. An `sk` rise seen in the same cycle as the select fall is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Serial chip select, active high |
| sk | input | 1 | Serial clock from host |
| di | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out value |
| do_oe | output | 1 | Serial data out enable (0 = high impedance) |
| seq_busy | input | 1 | Sequencer busy flag |
| mem_we | input | 1 | Array write strobe from sequencer |
| mem_waddr | input | AW | Array write address |
| mem_wdata | input | WORD_W | Array write data |
| cmd_valid | output | 1 | Hand-off pulse |
| cmd_kind | output | 2 | 0 write, 1 erase, 2 erase-all, 3 write-all |
| cmd_addr | output | AW | Start address of handed-off command |
| cmd_words | output | PAW+1 | Complete data words collected |
| pbuf_idx | input | PAW | Page buffer read slot |
| pbuf_data | output | WORD_W | Page buffer read data |

## Verification
Two events can land in the same system-clock cycle: the falling select that hands a command to the sequencer, and a serial clock rise that would complete another data word. The bench provokes this by changing `cs` and `sk` on the same edge after one full byte and seven further bits of a write. Both pins pass through the same synchroniser depth, so the design sees the two events together. The hand-off is judged correct only if it reports exactly one word. A count of two would mean the clock rise was accepted after deselect.

// File: rtl/mw_pkg.sv
package mw_pkg;
  // operation code field
  localparam logic [1:0] OP_EXT   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_ERASE = 2'b11;
  // extended group selector (top two address bits)
  localparam logic [1:0] EX_WDIS  = 2'b00;
  localparam logic [1:0] EX_FILL  = 2'b01;
  localparam logic [1:0] EX_CLR   = 2'b10;
  localparam logic [1:0] EX_WENA  = 2'b11;

  typedef enum logic [2:0] {
    S_IDLE, S_HDR, S_READ, S_WDATA, S_HOLD
  } fsm_t;

  typedef enum logic [1:0] {
    K_WRITE = 2'd0, K_ERASE = 2'd1, K_CLRALL = 2'd2, K_FILLALL = 2'd3
  } cmd_kind_t;
endpackage

// File: rtl/mw_pin_sync.sv
module mw_pin_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic cs_lvl,
  output logic di_lvl,
  output logic sk_rise,
  output logic cs_fall
);
  logic [2:0] stg_q [SYNC_STAGES];
  logic       cs_prev_q, sk_prev_q;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[0] <= 3'b000;
          else        stg_q[0] <= {cs, sk, di};
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[g] <= 3'b000;
          else        stg_q[g] <= stg_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_prev_q <= 1'b0;
      sk_prev_q <= 1'b0;
    end else begin
      cs_prev_q <= stg_q[SYNC_STAGES-1][2];
      sk_prev_q <= stg_q[SYNC_STAGES-1][1];
    end
  end

  assign cs_lvl  = stg_q[SYNC_STAGES-1][2];
  assign di_lvl  = stg_q[SYNC_STAGES-1][0];
  assign sk_rise = stg_q[SYNC_STAGES-1][1] & ~sk_prev_q;
  assign cs_fall = ~stg_q[SYNC_STAGES-1][2] & cs_prev_q;
endmodule

// File: rtl/mw_mem.sv
module mw_mem #(
  parameter int WORD_W = 8,
  parameter int DEPTH  = 512,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] arr_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) arr_q[waddr] <= wdata;
  end

  assign rdata = arr_q[raddr];
endmodule

// File: rtl/mw_page_buf.sv
module mw_page_buf #(
  parameter int WORD_W     = 8,
  parameter int PAGE_WORDS = 16,
  localparam int PAW       = $clog2(PAGE_WORDS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PAW-1:0]    widx,
  input  logic [WORD_W-1:0] wdata,
  input  logic [PAW-1:0]    ridx,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] slot_q [PAGE_WORDS];

  always_ff @(posedge clk) begin
    if (we) slot_q[widx] <= wdata;
  end

  assign rdata = slot_q[ridx];
endmodule

// File: rtl/mw_cmd_if.sv
module mw_cmd_if
  import mw_pkg::*;
#(
  parameter int WORD_W      = 8,
  parameter int MEM_BITS    = 4096,
  parameter int PAGE_BITS   = 128,
  parameter int SYNC_STAGES = 2,
  localparam int DEPTH      = MEM_BITS / WORD_W,
  localparam int AW         = $clog2(DEPTH),
  localparam int PAGE_WORDS = PAGE_BITS / WORD_W,
  localparam int PAW        = $clog2(PAGE_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              sk,
  input  logic              di,
  output logic              do_o,
  output logic              do_oe,
  input  logic              seq_busy,
  input  logic              mem_we,
  input  logic [AW-1:0]     mem_waddr,
  input  logic [WORD_W-1:0] mem_wdata,
  output logic              cmd_valid,
  output logic [1:0]        cmd_kind,
  output logic [AW-1:0]     cmd_addr,
  output logic [PAW:0]      cmd_words,
  input  logic [PAW-1:0]    pbuf_idx,
  output logic [WORD_W-1:0] pbuf_data
);
  localparam int HDR_BITS = 2 + AW;
  localparam int CNT_MAX  = (HDR_BITS > WORD_W) ? HDR_BITS : WORD_W;
  localparam int CW       = $clog2(CNT_MAX);
  localparam logic [CW-1:0]  HDR_LAST  = CW'(HDR_BITS - 1);
  localparam logic [CW-1:0]  WORD_LAST = CW'(WORD_W - 1);
  localparam logic [PAW:0]   PAGE_FULL = (PAW+1)'(PAGE_WORDS);

  // pin sampling
  logic cs_lvl, di_lvl, sk_rise, cs_fall;

  mw_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs     (cs),
    .sk     (sk),
    .di     (di),
    .cs_lvl (cs_lvl),
    .di_lvl (di_lvl),
    .sk_rise(sk_rise),
    .cs_fall(cs_fall)
  );

  // state
  fsm_t              state_q, state_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [HDR_BITS-2:0] hdr_q, hdr_d;
  logic [AW-1:0]     rd_addr_q, rd_addr_d;
  logic [WORD_W-1:0] rd_sh_q, rd_sh_d;
  logic              dout_q, dout_d;
  logic [WORD_W-2:0] wsh_q, wsh_d;
  logic [PAW-1:0]    wslot_q, wslot_d;
  logic [PAW:0]      wcount_q, wcount_d;
  logic              wen_q, wen_d;
  logic              stat_q, stat_d;
  logic              pend_q, pend_d;
  cmd_kind_t         pkind_q, pkind_d;
  logic [AW-1:0]     paddr_q, paddr_d;
  logic              cmd_v_q, cmd_v_d;
  cmd_kind_t         cmd_kind_q, cmd_kind_d;
  logic [AW-1:0]     cmd_addr_q, cmd_addr_d;
  logic [PAW:0]      cmd_words_q, cmd_words_d;

  // datapath helpers
  logic [HDR_BITS-1:0] hdr_full;
  logic [1:0]          hdr_op;
  logic [AW-1:0]       hdr_addr;
  logic [1:0]          hdr_ext;
  logic [WORD_W-1:0]   wword;
  logic [AW-1:0]       mem_raddr;
  logic [WORD_W-1:0]   mem_rdata;
  logic                pb_we;
  logic                rd_act;

  assign hdr_full = {hdr_q, di_lvl};
  assign hdr_op   = hdr_full[HDR_BITS-1 -: 2];
  assign hdr_addr = hdr_full[AW-1:0];
  assign hdr_ext  = hdr_addr[AW-1 -: 2];
  assign wword    = {wsh_q, di_lvl};

  mw_mem #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_mem (
    .clk  (clk),
    .we   (mem_we),
    .waddr(mem_waddr),
    .wdata(mem_wdata),
    .raddr(mem_raddr),
    .rdata(mem_rdata)
  );

  mw_page_buf #(.WORD_W(WORD_W), .PAGE_WORDS(PAGE_WORDS)) u_pbuf (
    .clk  (clk),
    .we   (pb_we),
    .widx (wslot_q),
    .wdata(wword),
    .ridx (pbuf_idx),
    .rdata(pbuf_data)
  );

  // next-state logic
  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    hdr_d       = hdr_q;
    rd_addr_d   = rd_addr_q;
    rd_sh_d     = rd_sh_q;
    dout_d      = dout_q;
    wsh_d       = wsh_q;
    wslot_d     = wslot_q;
    wcount_d    = wcount_q;
    wen_d       = wen_q;
    stat_d      = stat_q;
    pend_d      = pend_q;
    pkind_d     = pkind_q;
    paddr_d     = paddr_q;
    cmd_v_d     = 1'b0;
    cmd_kind_d  = cmd_kind_q;
    cmd_addr_d  = cmd_addr_q;
    cmd_words_d = cmd_words_q;
    mem_raddr   = rd_addr_q + AW'(1);
    pb_we       = 1'b0;

    if (cs_fall) begin
      // deselect: hand off a pending command, clear the instruction
      state_d = S_IDLE;
      pend_d  = 1'b0;
      if (pend_q) begin
        cmd_v_d     = 1'b1;
        cmd_kind_d  = pkind_q;
        cmd_addr_d  = paddr_q;
        cmd_words_d = wcount_q;
        stat_d      = 1'b1;
      end
    end else if (!cs_lvl) begin
      state_d = S_IDLE;
      pend_d  = 1'b0;
    end else if (sk_rise) begin
      unique case (state_q)
        S_IDLE: begin
          if (di_lvl) begin
            state_d = S_HDR;
            cnt_d   = '0;
            stat_d  = 1'b0;
          end
        end
        S_HDR: begin
          hdr_d = hdr_full[HDR_BITS-2:0];
          cnt_d = cnt_q + CW'(1);
          if (cnt_q == HDR_LAST) begin
            cnt_d    = '0;
            wcount_d = '0;
            unique case (hdr_op)
              OP_READ: begin
                state_d   = S_READ;
                rd_addr_d = hdr_addr;
                mem_raddr = hdr_addr;
                rd_sh_d   = mem_rdata;
                dout_d    = 1'b0;
              end
              OP_WRITE: begin
                state_d = S_WDATA;
                pkind_d = K_WRITE;
                paddr_d = hdr_addr;
                wslot_d = hdr_addr[PAW-1:0];
              end
              OP_ERASE: begin
                state_d = S_HOLD;
                pkind_d = K_ERASE;
                paddr_d = hdr_addr;
                pend_d  = wen_q;
              end
              default: begin
                unique case (hdr_ext)
                  EX_WENA: begin
                    state_d = S_HOLD;
                    wen_d   = 1'b1;
                  end
                  EX_WDIS: begin
                    state_d = S_HOLD;
                    wen_d   = 1'b0;
                  end
                  EX_CLR: begin
                    state_d = S_HOLD;
                    pkind_d = K_CLRALL;
                    paddr_d = '0;
                    pend_d  = wen_q;
                  end
                  default: begin
                    state_d = S_WDATA;
                    pkind_d = K_FILLALL;
                    paddr_d = '0;
                    wslot_d = '0;
                  end
                endcase
              end
            endcase
          end
        end
        S_READ: begin
          dout_d  = rd_sh_q[WORD_W-1];
          rd_sh_d = {rd_sh_q[WORD_W-2:0], 1'b0};
          cnt_d   = cnt_q + CW'(1);
          if (cnt_q == WORD_LAST) begin
            cnt_d     = '0;
            rd_addr_d = rd_addr_q + AW'(1);
            rd_sh_d   = mem_rdata;
          end
        end
        S_WDATA: begin
          wsh_d = wword[WORD_W-2:0];
          cnt_d = cnt_q + CW'(1);
          if (cnt_q == WORD_LAST) begin
            cnt_d   = '0;
            pb_we   = 1'b1;
            wslot_d = wslot_q + PAW'(1);
            if (wcount_q != PAGE_FULL) wcount_d = wcount_q + (PAW+1)'(1);
            if (wen_q) pend_d = 1'b1;
            if (pkind_q == K_FILLALL) state_d = S_HOLD;
          end
        end
        default: ;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      cnt_q       <= '0;
      hdr_q       <= '0;
      rd_addr_q   <= '0;
      rd_sh_q     <= '0;
      dout_q      <= 1'b0;
      wsh_q       <= '0;
      wslot_q     <= '0;
      wcount_q    <= '0;
      wen_q       <= 1'b0;
      stat_q      <= 1'b0;
      pend_q      <= 1'b0;
      pkind_q     <= K_WRITE;
      paddr_q     <= '0;
      cmd_v_q     <= 1'b0;
      cmd_kind_q  <= K_WRITE;
      cmd_addr_q  <= '0;
      cmd_words_q <= '0;
    end else begin
      state_q     <= state_d;
      cnt_q       <= cnt_d;
      hdr_q       <= hdr_d;
      rd_addr_q   <= rd_addr_d;
      rd_sh_q     <= rd_sh_d;
      dout_q      <= dout_d;
      wsh_q       <= wsh_d;
      wslot_q     <= wslot_d;
      wcount_q    <= wcount_d;
      wen_q       <= wen_d;
      stat_q      <= stat_d;
      pend_q      <= pend_d;
      pkind_q     <= pkind_d;
      paddr_q     <= paddr_d;
      cmd_v_q     <= cmd_v_d;
      cmd_kind_q  <= cmd_kind_d;
      cmd_addr_q  <= cmd_addr_d;
      cmd_words_q <= cmd_words_d;
    end
  end

  // outputs
  assign rd_act    = (state_q == S_READ);
  assign do_oe     = cs_lvl && (rd_act || (state_q == S_IDLE && stat_q));
  assign do_o      = rd_act ? dout_q : ~seq_busy;
  assign cmd_valid = cmd_v_q;
  assign cmd_kind  = cmd_kind_q;
  assign cmd_addr  = cmd_addr_q;
  assign cmd_words = cmd_words_q;
endmodule

// File: rtl/mw_cmd_if_chk.sv
module mw_cmd_if_chk #(
  parameter int PAGE_WORDS = 16,
  parameter int PAW        = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cs_lvl,
  input logic         cs_fall,
  input logic         do_oe,
  input logic         do_o,
  input logic         rd_act,
  input logic         wen_q,
  input logic         cmd_valid,
  input logic [PAW:0] cmd_words
);
  // R4: output driver only while selected
  a_r4_oe_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_lvl |-> !do_oe);

  // R2: entering a read presents the dummy zero
  a_r2_dummy_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_act) |-> !do_o);

  // R11: hand-off is one cycle wide
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  // R11: hand-off follows a deselect
  a_r11_after_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(cs_fall));

  // R6: no hand-off while writes are disabled
  a_r6_enable_gates: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> wen_q);

  // R7: word count never exceeds one page
  a_r7_count_capped: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_words <= (PAW+1)'(PAGE_WORDS)));
endmodule

bind mw_cmd_if mw_cmd_if_chk #(.PAGE_WORDS(PAGE_WORDS), .PAW(PAW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_lvl   (cs_lvl),
  .cs_fall  (cs_fall),
  .do_oe    (do_oe),
  .do_o     (do_o),
  .rd_act   (rd_act),
  .wen_q    (wen_q),
  .cmd_valid(cmd_valid),
  .cmd_words(cmd_words)
);

// File: tb/mw_cmd_if_tb.sv
module mw_cmd_if_tb;
  localparam int WW  = 8;
  localparam int AW  = 9;
  localparam int PAW = 4;
  localparam int HP  = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 1'b0, sk = 1'b0, di = 1'b0, seq_busy = 1'b0;
  logic mem_we = 1'b0;
  logic [AW-1:0] mem_waddr = '0;
  logic [WW-1:0] mem_wdata = '0;
  logic [PAW-1:0] pbuf_idx = '0;
  logic do_o, do_oe, cmd_valid;
  logic [1:0] cmd_kind;
  logic [AW-1:0] cmd_addr;
  logic [PAW:0] cmd_words;
  logic [WW-1:0] pbuf_data;

  always #10 clk = ~clk;

  mw_cmd_if u_dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di),
    .do_o(do_o), .do_oe(do_oe), .seq_busy(seq_busy),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr),
    .cmd_words(cmd_words), .pbuf_idx(pbuf_idx), .pbuf_data(pbuf_data)
  );

  typedef struct { logic oe; logic val; string tag; } exp_t;
  exp_t q[$];
  int n_cmp = 0, n_bad = 0;
  int got_n = 0, got_kind = 0, got_addr = 0, got_words = 0;
  event smp_ev;

  // monitor: compares DO against the expectation queue
  always @(smp_ev) begin
    exp_t e;
    if (q.size() > 0) begin
      e = q.pop_front();
      n_cmp++;
      if (do_oe !== e.oe || (e.oe && do_o !== e.val)) begin
        n_bad++;
        $display("FAIL %s: DO oe/val got %b/%b expected %b/%b",
                 e.tag, do_oe, do_o, e.oe, e.val);
      end
    end
  end

  // monitor: captures hand-offs
  always @(posedge clk) begin
    if (rst_n && cmd_valid) begin
      got_n++;
      got_kind  = int'(cmd_kind);
      got_addr  = int'(cmd_addr);
      got_words = int'(cmd_words);
    end
  end

  function automatic logic [WW-1:0] mval(int a);
    return WW'((a * 29 + 7) ^ (a >> 3));
  endfunction

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int expv);
    n_cmp++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic expect_do(logic oe, logic val, string tag);
    exp_t e;
    e.oe = oe; e.val = val; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic skb(logic b);
    di = b;
    tick(HP);
    sk = 1'b1;
    tick(HP);
    -> smp_ev;
    #1;
    sk = 1'b0;
  endtask

  task automatic look();
    tick(HP);
    -> smp_ev;
    #1;
  endtask

  task automatic sel();
    cs = 1'b1;
    tick(HP);
  endtask

  task automatic desel();
    sk = 1'b0;
    tick(HP);
    cs = 1'b0;
    tick(3 * HP);
  endtask

  task automatic hdr(logic [1:0] op, logic [AW-1:0] a, bit is_rd, string tag);
    expect_do(1'b0, 1'b0, "R4 start bit");
    skb(1'b1);
    expect_do(1'b0, 1'b0, "R4 opcode");
    skb(op[1]);
    skb(op[0]);
    for (int i = AW - 1; i >= 0; i--) begin
      if (i == 0 && is_rd) expect_do(1'b1, 1'b0, tag);
      else if (i == AW - 1) expect_do(1'b0, 1'b0, "R4 address");
      skb(a[i]);
    end
  endtask

  task automatic rd_word(logic [WW-1:0] w, string tag);
    for (int i = WW - 1; i >= 0; i--) begin
      expect_do(1'b1, w[i], tag);
      skb(1'b0);
    end
  endtask

  task automatic wr_word(logic [WW-1:0] w);
    for (int i = WW - 1; i >= 0; i--) skb(w[i]);
  endtask

  task automatic ext(logic [1:0] e);
    hdr(2'b00, {e, 7'b0}, 1'b0, "");
  endtask

  task automatic pb(int idx, int expv, string tag);
    pbuf_idx = PAW'(idx);
    tick(1);
    chk(tag, int'(pbuf_data), expv);
  endtask

  task automatic hand(int base, int kind, int addr, int words, string tag);
    chk({tag, " count"}, got_n, base + 1);
    chk({tag, " kind"}, got_kind, kind);
    chk({tag, " addr"}, got_addr, addr);
    chk({tag, " words"}, got_words, words);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int base;
    tick(4);
    rst_n = 1'b1;
    tick(4);
    // reset state: R4, R6
    chk("R4 reset oe", int'(do_oe), 0);
    chk("R6 reset no hand-off", got_n, 0);

    // preload array through the sequencer port
    for (int a = 0; a < (1 << AW); a++) begin
      mem_we = 1'b1; mem_waddr = AW'(a); mem_wdata = mval(a);
      tick(1);
    end
    mem_we = 1'b0;

    // R1: leading zeros ignored, then read (R2, R3), writes disabled (R6)
    sel();
    for (int i = 0; i < 3; i++) begin
      expect_do(1'b0, 1'b0, "R1 leading zero");
      skb(1'b0);
    end
    hdr(2'b10, 9'd5, 1'b1, "R2 dummy zero");
    rd_word(mval(5), "R2 R6 data word");
    rd_word(mval(6), "R3 next address");
    desel();
    chk("R4 oe after deselect", int'(do_oe), 0);

    // R3: wrap from top address to zero
    sel();
    hdr(2'b10, 9'h1FF, 1'b1, "R3 dummy zero");
    rd_word(mval(511), "R3 top word");
    rd_word(mval(0), "R3 wrapped word");
    desel();

    // R5: partial header abandoned
    sel();
    skb(1'b1); skb(1'b1); skb(1'b0); skb(1'b1); skb(1'b0);
    desel();
    sel();
    hdr(2'b10, 9'd100, 1'b1, "R5 dummy zero");
    rd_word(mval(100), "R5 fresh read");
    desel();

    // R6: disabled write and erase give no hand-off
    base = got_n;
    sel(); hdr(2'b01, 9'd20, 1'b0, ""); wr_word(8'h11); desel();
    sel(); hdr(2'b11, 9'd3, 1'b0, ""); desel();
    chk("R6 disabled no hand-off", got_n, base);

    // R6 enable, R7 write with slot wrap and partial word
    sel(); ext(2'b11); desel();
    base = got_n;
    sel();
    hdr(2'b01, 9'd14, 1'b0, "");
    wr_word(8'hA1); wr_word(8'hB2); wr_word(8'hC3);
    skb(1'b1); skb(1'b0); skb(1'b1);
    desel();
    hand(base, 0, 14, 3, "R7 write");
    pb(14, 8'hA1, "R7 slot 14");
    pb(15, 8'hB2, "R7 slot 15");
    pb(0, 8'hC3, "R7 slot wrap 0");

    // R10: status after hand-off, cleared by start bit
    seq_busy = 1'b1;
    sel();
    expect_do(1'b1, 1'b0, "R10 busy");
    look();
    seq_busy = 1'b0;
    expect_do(1'b1, 1'b1, "R10 ready");
    look();
    expect_do(1'b0, 1'b0, "R10 cleared by start");
    skb(1'b1);
    desel();
    sel();
    expect_do(1'b0, 1'b0, "R10 stays cleared");
    look();
    desel();

    // R7: seventeen bytes, count capped, slot overwritten
    base = got_n;
    sel();
    hdr(2'b01, 9'h020, 1'b0, "");
    for (int k = 0; k < 17; k++) wr_word(WW'(8'h40 + k));
    desel();
    hand(base, 0, 32, 16, "R7 page cap");
    pb(0, 8'h50, "R7 overwritten slot 0");
    pb(1, 8'h41, "R7 slot 1");
    pb(15, 8'h4F, "R7 slot 15");

    // R8: erase and erase-all
    base = got_n;
    sel(); hdr(2'b11, 9'h123, 1'b0, ""); desel();
    hand(base, 1, 291, 0, "R8 erase");
    base = got_n;
    sel(); ext(2'b10); desel();
    hand(base, 2, 0, 0, "R8 erase all");

    // R9: write-all
    base = got_n;
    sel(); ext(2'b01); wr_word(8'h5A); desel();
    hand(base, 3, 0, 1, "R9 write all");
    pb(0, 8'h5A, "R9 slot 0");

    // R11: SK rise coinciding with deselect is ignored
    base = got_n;
    sel();
    hdr(2'b01, 9'h040, 1'b0, "");
    wr_word(8'h77);
    for (int i = 0; i < 7; i++) skb(1'b1);
    di = 1'b1;
    tick(HP);
    sk = 1'b1; cs = 1'b0;
    tick(4 * HP);
    sk = 1'b0;
    tick(HP);
    hand(base, 0, 64, 1, "R11 coincident edge");

    // R6: disable again, write ignored, read still works
    sel(); ext(2'b00); desel();
    base = got_n;
    sel(); hdr(2'b01, 9'd8, 1'b0, ""); wr_word(8'h33); desel();
    chk("R6 after disable no hand-off", got_n, base);
    sel();
    hdr(2'b10, 9'd7, 1'b1, "R6 read dummy");
    rd_word(mval(7), "R6 read while disabled");
    desel();

    tick(10);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule